// File: doc/BRIEF.md
# Row-Based Flash Write Guard

This block models a small flash array held in registers and enforces the programming rules of flash memory. Programming acts on one page at a time and can only clear bits: each stored word becomes the bitwise AND of its old value and the written value. The only way to return bits to one is a row erase, which acts on all four pages of a row together.

Every row has its own count of programs accepted since that row was last erased. Once a row reaches the write limit, any further program to it is refused until the row is erased. A refused program leaves the contents alone, does not advance the count and sets a sticky error flag.

Program and erase each hold `busy` high for a fixed number of cycles. Any command presented while `busy` is high is dropped. Reads return one 32-bit word, which appears on the cycle after the read strobe is accepted.

Top module: `rowflash_guard`

## Requirements
- R1: After reset, every word reads 32'hFFFFFFFF, `busy` and `err` are 0, `rd_data` is all ones, and every row accepts programs.
- R2: An accepted program to a page sets each of the page's four words to old AND new. Word k takes `wr_data[32k+31:32k]`. Words outside the page keep their values. A program can never set a bit to 1.
- R3: An accepted erase sets all 16 words of the addressed row to all ones and resets that row's write count to zero. Other rows keep their contents.
- R4: A row accepts exactly WRITE_LIMIT (8) programs between erases. A further program to that row is refused, and the row's contents stay unchanged.
- R5: A refused program sets `err` and does not raise `busy`. `err` stays 1 until reset, including across later erases and accepted programs.
- R6: `busy` is high for PROG_CYCLES (4) cycles after an accepted program and for ERASE_CYCLES (6) cycles after an accepted erase. In both cases it starts on the cycle after the accepting edge.
- R7: While `busy` is high, all strobes are ignored. No program or erase takes effect, and `rd_data` does not change.
- R8: When strobes coincide, erase takes precedence over program, and program takes precedence over read. The strobe that loses has no effect.
- R9: The word address is {row `addr[6:4]`, page `addr[3:2]`, word `addr[1:0]`}. Program ignores the word bits, and erase ignores both the page and word bits. `rd_data` shows the addressed word from the cycle after the read is accepted.
- R10: Write counts are kept per row. Filling or erasing one row does not change whether another row accepts programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_req | input | 1 | Program strobe for the page at `addr` |
| erase_req | input | 1 | Erase strobe for the row at `addr` |
| rd_req | input | 1 | Read strobe for the word at `addr` |
| addr | input | 7 | Word address {row, page, word} |
| wr_data | input | 128 | Page data, word k in bits 32k+31:32k |
| rd_data | output | 32 | Last word read |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky flag for a refused program |

## Verification
The assertions check the following on every cycle:
- `err` never falls once it has risen.
- A refused program sets `err` and leaves `busy` low.
- Every accepted program or erase raises `busy` on the next cycle.
- A busy run never exceeds the longer of the two durations.
- The addressed row's count never passes the limit.
- A read strobe during `busy` leaves `rd_data` unchanged.

Only the bench's scenarios can show the following:
- The AND-only data effect and that erase restores all ones.
- Which rows and pages an operation touches.
- That exactly eight programs are accepted before the first refusal, and that an erase restores a full eight.
- The exact busy lengths and the precedence among strobes that arrive together.

// File: rtl/rfg_pkg.sv
// Shared types for the row flash write guard.
// Assumes one operation at most is accepted per cycle.
package rfg_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;
endpackage

// File: rtl/rfg_ctrl.sv
// Command acceptance and busy timing.
// Picks at most one operation per cycle (erase, then program, then read),
// refuses a program to a full row, keeps the sticky error flag, and holds
// busy for a fixed number of cycles after a program or an erase.
// Assumes row_full describes the row currently on the address bus.
module rfg_ctrl
    import rfg_pkg::*;
#(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_req,
    input  logic erase_req,
    input  logic rd_req,
    input  logic row_full,
    output op_e  op,
    output logic busy,
    output logic err
);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int TMR_W = $clog2(MAXC + 1);

    logic [TMR_W-1:0] tmr_q;
    logic             busy_q;
    logic             err_q;
    logic             reject;

    // Decide which strobe, if any, is accepted this cycle.
    always_comb begin
        op     = OP_IDLE;
        reject = 1'b0;
        if (!busy_q) begin
            if (erase_req) begin
                op = OP_ERASE;
            end else if (prog_req) begin
                if (row_full) begin
                    reject = 1'b1;
                end else begin
                    op = OP_PROG;
                end
            end else if (rd_req) begin
                op = OP_READ;
            end
        end
    end

    // Busy timer: load on program or erase, count down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
        end else if (op == OP_PROG) begin
            busy_q <= 1'b1;
            tmr_q  <= TMR_W'(PROG_CYCLES - 1);
        end else if (op == OP_ERASE) begin
            busy_q <= 1'b1;
            tmr_q  <= TMR_W'(ERASE_CYCLES - 1);
        end else if (busy_q) begin
            if (tmr_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    // Sticky error: set by a refused program, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end
    end

    assign busy = busy_q;
    assign err  = err_q;
endmodule

// File: rtl/rfg_wcount.sv
// Per-row count of programs accepted since the last erase.
// One saturating-by-construction counter per row: the controller never
// accepts a program to a row whose count has reached the limit.
// Assumes op is the operation accepted this cycle for row row_sel.
module rfg_wcount
    import rfg_pkg::*;
#(
    parameter int ROWS        = 8,
    parameter int ROW_W       = 3,
    parameter int WRITE_LIMIT = 8,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [ROW_W-1:0] row_sel,
    output logic [CNT_W-1:0] row_cnt,
    output logic             row_full
);
    logic [CNT_W-1:0] cnt_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row counter: cleared by its row's erase, advanced by its row's program.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[r] <= '0;
            end else if (row_sel == ROW_W'(r)) begin
                if (op == OP_ERASE) begin
                    cnt_q[r] <= '0;
                end else if (op == OP_PROG) begin
                    cnt_q[r] <= cnt_q[r] + 1'b1;
                end
            end
        end
    end

    // Count and limit flag of the addressed row.
    always_comb begin
        row_cnt  = cnt_q[row_sel];
        row_full = (row_cnt >= CNT_W'(WRITE_LIMIT));
    end
endmodule

// File: rtl/rfg_store.sv
// Register-array model of the flash cells.
// Each word is its own register. A program ANDs new data into the words
// of one page, and an erase sets every word of one row to ones.
// Reads are registered, so a word appears on the cycle after the read.
// Assumes word k of a page takes wr_data[k*DW +: DW].
module rfg_store
    import rfg_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int PAGES  = 4,
    parameter int WORDS  = 4,
    parameter int DW     = 32,
    parameter int ROW_W  = 3,
    parameter int PAGE_W = 2,
    parameter int WORD_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  op_e                   op,
    input  logic [ROW_W-1:0]      row_sel,
    input  logic [PAGE_W-1:0]     page_sel,
    input  logic [WORD_W-1:0]     word_sel,
    input  logic [WORDS*DW-1:0]   wr_data,
    output logic [DW-1:0]         rd_data
);
    localparam int NWORDS = ROWS * PAGES * WORDS;
    localparam int IDX_W  = ROW_W + PAGE_W + WORD_W;

    logic [DW-1:0]    cell_w [NWORDS];
    logic [DW-1:0]    rd_q;
    logic [IDX_W-1:0] rd_idx;

    for (genvar i = 0; i < NWORDS; i++) begin : g_cell
        localparam int ROW_OF  = i / (PAGES * WORDS);
        localparam int PAGE_OF = (i / WORDS) % PAGES;
        localparam int WORD_OF = i % WORDS;
        logic [DW-1:0] cell_q;

        // Cell update: erase of its row sets ones, program of its page clears bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '1;
            end else if (op == OP_ERASE && row_sel == ROW_W'(ROW_OF)) begin
                cell_q <= '1;
            end else if (op == OP_PROG && row_sel == ROW_W'(ROW_OF)
                         && page_sel == PAGE_W'(PAGE_OF)) begin
                cell_q <= cell_q & wr_data[WORD_OF*DW +: DW];
            end
        end

        assign cell_w[i] = cell_q;
    end

    assign rd_idx = {row_sel, page_sel, word_sel};

    // Read register: captures the addressed word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '1;
        end else if (op == OP_READ) begin
            rd_q <= cell_w[rd_idx];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/rowflash_guard.sv
// Top level of the row flash write guard.
// Splits the word address into row, page and word fields (row in the upper
// bits) and joins the controller, the per-row write counters and the cell
// store. Assumes WRITE_LIMIT is at least PAGES_PER_ROW so that every page
// of a row can be programmed once between erases.
module rowflash_guard
    import rfg_pkg::*;
#(
    parameter int ROWS           = 8,
    parameter int PAGES_PER_ROW  = 4,
    parameter int WORDS_PER_PAGE = 4,
    parameter int DATA_W         = 32,
    parameter int WRITE_LIMIT    = 8,
    parameter int PROG_CYCLES    = 4,
    parameter int ERASE_CYCLES   = 6,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int PAGE_W = $clog2(PAGES_PER_ROW),
    localparam int WORD_W = $clog2(WORDS_PER_PAGE),
    localparam int ADDR_W = ROW_W + PAGE_W + WORD_W,
    localparam int PAGE_BITS = WORDS_PER_PAGE * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_req,
    input  logic                 erase_req,
    input  logic                 rd_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PAGE_BITS-1:0] wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 err
);
    localparam int CNT_W = $clog2(WRITE_LIMIT + 1);

    if (WRITE_LIMIT < PAGES_PER_ROW) begin : g_limit_bad
        $error("WRITE_LIMIT must be at least PAGES_PER_ROW");
    end

    logic [ROW_W-1:0]  row_sel;
    logic [PAGE_W-1:0] page_sel;
    logic [WORD_W-1:0] word_sel;
    logic [CNT_W-1:0]  row_cnt;
    logic              row_full;
    op_e               op;

    assign row_sel  = addr[ADDR_W-1 -: ROW_W];
    assign page_sel = addr[WORD_W +: PAGE_W];
    assign word_sel = addr[WORD_W-1:0];

    rfg_ctrl #(
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_req (prog_req),
        .erase_req(erase_req),
        .rd_req   (rd_req),
        .row_full (row_full),
        .op       (op),
        .busy     (busy),
        .err      (err)
    );

    rfg_wcount #(
        .ROWS       (ROWS),
        .ROW_W      (ROW_W),
        .WRITE_LIMIT(WRITE_LIMIT),
        .CNT_W      (CNT_W)
    ) u_wcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .row_sel (row_sel),
        .row_cnt (row_cnt),
        .row_full(row_full)
    );

    rfg_store #(
        .ROWS  (ROWS),
        .PAGES (PAGES_PER_ROW),
        .WORDS (WORDS_PER_PAGE),
        .DW    (DATA_W),
        .ROW_W (ROW_W),
        .PAGE_W(PAGE_W),
        .WORD_W(WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .row_sel (row_sel),
        .page_sel(page_sel),
        .word_sel(word_sel),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/rfg_checker.sv
// Cycle-level properties of the row flash write guard, bound to its top.
// Assumes it observes the top's ports plus the addressed row's count and
// limit flag, which the counter module drives.
module rfg_checker #(
    parameter int WRITE_LIMIT  = 8,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 6,
    parameter int DW           = 32,
    parameter int CNT_W        = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_req,
    input logic             erase_req,
    input logic             rd_req,
    input logic             busy,
    input logic             err,
    input logic             row_full,
    input logic [CNT_W-1:0] row_cnt,
    input logic [DW-1:0]    rd_data
);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int RUN_W = $clog2(MAXC + 2);

    logic [RUN_W-1:0] run_q;

    // Length of the current busy run, in cycles already spent busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            if (run_q != '1) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r5_reject_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !erase_req && prog_req && row_full) |=> (err && !busy));

    a_r6_prog_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !erase_req && prog_req && !row_full) |=> busy);

    a_r8_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_req) |=> busy);

    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(MAXC)));

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        row_cnt <= CNT_W'(WRITE_LIMIT));

    a_r7_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_req) |=> $stable(rd_data));
endmodule

bind rowflash_guard rfg_checker #(
    .WRITE_LIMIT (WRITE_LIMIT),
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .DW          (DATA_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_req (prog_req),
    .erase_req(erase_req),
    .rd_req   (rd_req),
    .busy     (busy),
    .err      (err),
    .row_full (row_full),
    .row_cnt  (row_cnt),
    .rd_data  (rd_data)
);

// File: tb/sim_rowflash_guard.sv
module sim_rowflash_guard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_req = 1'b0;
    logic         erase_req = 1'b0;
    logic         rd_req = 1'b0;
    logic [6:0]   addr = '0;
    logic [127:0] wr_data = '0;
    logic [31:0]  rd_data;
    logic         busy;
    logic         err;

    int errs = 0;
    int checks = 0;
    logic [31:0] v;
    int n;

    always #5 clk = ~clk;

    rowflash_guard u0 (
        .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
        .rd_req(rd_req), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    // op: 0 read (compare exp), 1 program {4{data}}, 2 erase
    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 7'h00, 32'h0,         32'hFFFFFFFF}, // R1 erased
        '{2'd1, 7'h00, 32'hF0F0FFFF,  32'h0},        // R2 program row0 page0
        '{2'd0, 7'h00, 32'h0,         32'hF0F0FFFF}, // R2
        '{2'd0, 7'h03, 32'h0,         32'hF0F0FFFF}, // R2 all words of page
        '{2'd0, 7'h04, 32'h0,         32'hFFFFFFFF}, // R2 other page untouched
        '{2'd1, 7'h02, 32'hFFFF0F0F,  32'h0},        // R9 word bits ignored
        '{2'd0, 7'h01, 32'h0,         32'hF0F00F0F}, // R2 AND
        '{2'd1, 7'h00, 32'hFFFFFFFF,  32'h0},        // R2 cannot set bits
        '{2'd0, 7'h02, 32'h0,         32'hF0F00F0F}, // R2
        '{2'd1, 7'h14, 32'h12345678,  32'h0},        // row1 page1
        '{2'd0, 7'h17, 32'h0,         32'h12345678}, // R9
        '{2'd2, 7'h05, 32'h0,         32'h0},        // R9 erase ignores page bits
        '{2'd0, 7'h0F, 32'h0,         32'hFFFFFFFF}, // R3 row0 ones
        '{2'd0, 7'h15, 32'h0,         32'h12345678}  // R3 row1 kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic p, input logic e, input logic r,
                         input logic [6:0] a, input logic [127:0] d);
        @(negedge clk);
        prog_req = p; erase_req = e; rd_req = r; addr = a; wr_data = d;
        @(negedge clk);
        prog_req = 1'b0; erase_req = 1'b0; rd_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_prog(input logic [6:0] a, input logic [31:0] d);
        pulse(1'b1, 1'b0, 1'b0, a, {4{d}});
        wait_idle();
    endtask

    task automatic do_erase(input logic [6:0] a);
        pulse(1'b0, 1'b1, 1'b0, a, '0);
        wait_idle();
    endtask

    task automatic do_read(input logic [6:0] a, output logic [31:0] val);
        pulse(1'b0, 1'b0, 1'b1, a, '0);
        val = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 busy", {31'b0, busy}, 32'h0);
        check("R1 err", {31'b0, err}, 32'h0);
        check("R1 rd_data", rd_data, 32'hFFFFFFFF);
        do_read(7'h7F, v);
        check("R1 last word", v, 32'hFFFFFFFF);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: begin
                    do_read(VEC[i].a, v);
                    check("R2/R3/R9 table read", v, VEC[i].exp);
                end
                2'd1: begin
                    do_prog(VEC[i].a, VEC[i].d);
                    check("R4 table no refusal", {31'b0, err}, 32'h0);
                end
                default: do_erase(VEC[i].a);
            endcase
        end

        // R4 limit on row2
        do_reset();
        for (int i = 0; i < 8; i++) do_prog(7'h20, ~(32'h1 << i));
        check("R4 eight accepted err", {31'b0, err}, 32'h0);
        do_read(7'h20, v);
        check("R4 eight accepted data", v, 32'hFFFFFF00);
        pulse(1'b1, 1'b0, 1'b0, 7'h20, '0);
        check("R5 refused no busy", {31'b0, busy}, 32'h0);
        check("R5 refused err", {31'b0, err}, 32'h1);
        do_read(7'h20, v);
        check("R4 ninth unchanged", v, 32'hFFFFFF00);
        // R10 other row still writable
        do_prog(7'h30, 32'h0F0F0F0F);
        do_read(7'h30, v);
        check("R10 row3 accepted", v, 32'h0F0F0F0F);
        // R3 erase clears count
        do_erase(7'h2C);
        do_read(7'h23, v);
        check("R3 erase row2", v, 32'hFFFFFFFF);
        do_read(7'h31, v);
        check("R3 row3 kept", v, 32'h0F0F0F0F);
        check("R5 err sticky after erase", {31'b0, err}, 32'h1);
        for (int i = 0; i < 8; i++) do_prog(7'h24, ~(32'h100 << i));
        do_read(7'h24, v);
        check("R3 count cleared", v, 32'hFFFF00FF);
        pulse(1'b1, 1'b0, 1'b0, 7'h24, '0);
        wait_idle();
        do_read(7'h24, v);
        check("R4 refused again", v, 32'hFFFF00FF);
        check("R5 err sticky", {31'b0, err}, 32'h1);

        // R1 reset restores erased state
        do_reset();
        check("R1 err cleared", {31'b0, err}, 32'h0);
        do_read(7'h24, v);
        check("R1 row2 erased", v, 32'hFFFFFFFF);

        // R6 busy lengths
        pulse(1'b1, 1'b0, 1'b0, 7'h50, {4{32'h0000FFFF}});
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R6 program busy", n, 32'd4);
        pulse(1'b0, 1'b1, 1'b0, 7'h50, '0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R6 erase busy", n, 32'd6);

        // R7 ignored while busy
        do_read(7'h00, v);
        pulse(1'b1, 1'b0, 1'b0, 7'h20, '0);
        pulse(1'b0, 1'b0, 1'b1, 7'h20, '0);
        check("R7 read ignored", rd_data, 32'hFFFFFFFF);
        pulse(1'b1, 1'b0, 1'b0, 7'h00, '0);
        wait_idle();
        do_read(7'h00, v);
        check("R7 program ignored", v, 32'hFFFFFFFF);
        do_read(7'h20, v);
        check("R7 first program applied", v, 32'h00000000);

        // R8 precedence
        pulse(1'b1, 1'b1, 1'b0, 7'h20, '0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R8 erase wins busy", n, 32'd6);
        do_read(7'h20, v);
        check("R8 erase wins data", v, 32'hFFFFFFFF);
        do_prog(7'h40, 32'h0);
        do_read(7'h40, v);
        check("R8 setup", v, 32'h0);
        pulse(1'b1, 1'b0, 1'b1, 7'h30, {4{32'hAAAAAAAA}});
        check("R8 read loses", rd_data, 32'h0);
        wait_idle();
        do_read(7'h30, v);
        check("R8 program wins", v, 32'hAAAAAAAA);

        finish_run();
    end
endmodule